// File: doc/BRIEF.md
# Two-Tier Cache Placement Controller

This block manages the tag side of a last-level cache built from two kinds of bank: a small fast tier and a larger, denser slow tier. Each tier is a set-associative array of tags with valid and dirty bits and its own least-recently-used order. The slow tier keeps its tags in a central tag directory, so a single lookup checks the fast-tier tags and the directory together and never has to probe the slow banks to find a block.

Placement follows one rule. A block fetched from memory on a miss is always written into the slow tier. If a later request hits it there, the block is promoted into the fast tier. The fast-tier block it displaces is moved down into the slow tier, into the way the promoted block just left. Only blocks that fall out of the slow tier leave the cache, and a dirty one raises a writeback request. Each response reports hit or miss, which tier answered, and a modelled latency in cycles. That latency is 4 for a fast-tier access, 6 for a slow-tier access, and 6 plus the memory latency for a miss.

Requests use a valid/ready handshake. The controller takes one request at a time and keeps ready low until it has finished all of that request's tag and order updates, including a promotion swap.

Top module: `tpc_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and wb_valid are 0, both tiers hold no valid block, and every way order equals way index order. Way 7 is the least recently used way of each set.
- R2: A request is taken on a rising edge with req_valid and req_ready both high. req_ready is 0 in the cycle that follows.
- R3: A fast-tier hit gives rsp_valid for one cycle after the second edge counted from acceptance, with rsp_hit=1, rsp_tier=1 and rsp_lat=4. A write marks the block dirty.
- R4: A miss gives a response after the third edge with rsp_hit=0, rsp_tier=0 and rsp_lat=256. The block is installed in the slow tier only. The next access to it reports rsp_tier=2.
- R5: A slow-tier hit gives a response after the third edge with rsp_hit=1, rsp_tier=2 and rsp_lat=6. The block moves into the least recently used fast way.
- R6: The fast-tier block displaced by a promotion is placed into the slow-tier way the promoted block vacated. A later access to it reports rsp_tier=2.
- R7: A block is held in one tier only. After a promotion, the block reports rsp_tier=1 and never 2.
- R8: Within each tier and set, the victim is the least recently used way. Any access, fill or swap that touches a way makes it the most recently used in its tier.
- R9: When a slow-tier victim that is both valid and dirty is replaced on a miss, wb_valid pulses for one cycle together with the miss response, and wb_addr = {victim tag, set}. A clean victim gives no pulse.
- R10: req_ready stays 0 from acceptance until the response cycle and is 1 in the response cycle. Each accepted request produces exactly one response.
- R11: The dirty bit travels with the block through promotion and demotion. A write on a slow hit or on a miss marks the moved or installed block dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 12 | Block address; bits 1:0 select the set, bits 11:2 are the tag |
| req_write | input | 1 | Request writes the block (marks it dirty) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Block was found in either tier |
| rsp_tier | output | 2 | 0 miss, 1 fast tier, 2 slow tier |
| rsp_lat | output | 10 | Modelled access latency in cycles |
| wb_valid | output | 1 | Dirty block leaving the cache |
| wb_addr | output | 12 | Block address of the written-back block |

## Verification
The assertions assume that req_valid is driven only in cycles when req_ready can be sampled, and that no block is ever present in both tiers. Only the controller's own fills and swaps place blocks, so the bench never preloads state. Instead it drives every placement through the request port and waits for each response before it issues the next request. Stimulus mixes reads and writes over a narrow set of tags in four sets. This forces frequent promotions, demotions and dirty evictions, so the single-tier property and the writeback timing are exercised in many orders.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    parameter int ADDR_W   = 12;
    parameter int SET_W    = 2;
    parameter int WAYS     = 8;
    parameter int FAST_LAT = 4;
    parameter int MEM_LAT  = 250;
    parameter int LAT_W    = 10;

    localparam int TAG_W    = ADDR_W - SET_W;
    localparam int SETS     = 1 << SET_W;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int SLOW_LAT = (3 * FAST_LAT + 1) / 2;
    localparam int MISS_LAT = SLOW_LAT + MEM_LAT;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } line_t;

    typedef enum logic [1:0] {
        TIER_NONE = 2'd0,
        TIER_FAST = 2'd1,
        TIER_SLOW = 2'd2
    } tier_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SWAP,
        ST_FILL
    } state_e;

    function automatic line_t make_line(input logic dirty, input logic [TAG_W-1:0] tag);
        line_t l;
        l.valid = 1'b1;
        l.dirty = dirty;
        l.tag   = tag;
        return l;
    endfunction
endpackage

// File: rtl/tpc_tag_store.sv
module tpc_tag_store
    import tpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o,
    output logic [WAY_W-1:0] hit_way_o,
    input  logic [WAY_W-1:0] rd_way_i,
    output line_t            rd_line_o,
    input  logic             wr_en_i,
    input  logic [WAY_W-1:0] wr_way_i,
    input  line_t            wr_line_i
);
    line_t lines [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
        end else if (wr_en_i) begin
            lines[set_i][wr_way_i] <= wr_line_i;
        end
    end

    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lines[set_i][w].valid && lines[set_i][w].tag == tag_i) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
        end
    end

    assign rd_line_o = lines[set_i][rd_way_i];
endmodule

// File: rtl/tpc_lru.sv
module tpc_lru
    import tpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] touch_way_i,
    output logic [WAY_W-1:0] victim_o
);
    logic [WAY_W-1:0] age [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way_i)
                    age[set_i][w] <= '0;
                else if (age[set_i][w] < age[set_i][touch_way_i])
                    age[set_i][w] <= age[set_i][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (age[set_i][w] == WAY_W'(WAYS - 1))
                victim_o = WAY_W'(w);
    end
endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
    import tpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_tier,
    output logic [LAT_W-1:0]  rsp_lat,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);
    state_e            st;
    logic [ADDR_W-1:0] q_addr;
    logic              q_wr;

    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    assign cur_set = q_addr[SET_W-1:0];
    assign cur_tag = q_addr[ADDR_W-1:SET_W];

    logic             f_hit, d_hit;
    logic [WAY_W-1:0] f_hit_way, d_hit_way, f_vic, s_vic;
    logic [WAY_W-1:0] f_rd_way, d_rd_way, f_wr_way, d_wr_way;
    logic [WAY_W-1:0] f_touch_way, s_touch_way;
    line_t            f_rd_line, d_rd_line, f_wr_line, d_wr_line;
    logic             f_wr, d_wr, f_touch, s_touch;

    // Fast-tier tags and the slow-tier tag directory share one store design.
    tpc_tag_store u_fast (
        .clk(clk), .rst(rst), .set_i(cur_set), .tag_i(cur_tag),
        .hit_o(f_hit), .hit_way_o(f_hit_way),
        .rd_way_i(f_rd_way), .rd_line_o(f_rd_line),
        .wr_en_i(f_wr), .wr_way_i(f_wr_way), .wr_line_i(f_wr_line)
    );

    tpc_tag_store u_dir (
        .clk(clk), .rst(rst), .set_i(cur_set), .tag_i(cur_tag),
        .hit_o(d_hit), .hit_way_o(d_hit_way),
        .rd_way_i(d_rd_way), .rd_line_o(d_rd_line),
        .wr_en_i(d_wr), .wr_way_i(d_wr_way), .wr_line_i(d_wr_line)
    );

    tpc_lru u_fast_lru (
        .clk(clk), .rst(rst), .set_i(cur_set),
        .touch_i(f_touch), .touch_way_i(f_touch_way), .victim_o(f_vic)
    );

    tpc_lru u_slow_lru (
        .clk(clk), .rst(rst), .set_i(cur_set),
        .touch_i(s_touch), .touch_way_i(s_touch_way), .victim_o(s_vic)
    );

    // Port steering per state; a swap rewrites both stores in one edge.
    always_comb begin
        f_rd_way    = (st == ST_LOOK) ? f_hit_way : f_vic;
        d_rd_way    = (st == ST_SWAP) ? d_hit_way : s_vic;
        f_wr        = 1'b0;
        f_wr_way    = f_hit_way;
        f_wr_line   = make_line(f_rd_line.dirty | q_wr, cur_tag);
        d_wr        = 1'b0;
        d_wr_way    = s_vic;
        d_wr_line   = make_line(q_wr, cur_tag);
        f_touch     = 1'b0;
        f_touch_way = f_hit_way;
        s_touch     = 1'b0;
        s_touch_way = s_vic;
        unique case (st)
            ST_LOOK: begin
                if (f_hit) begin
                    f_wr    = 1'b1;
                    f_touch = 1'b1;
                end
            end
            ST_SWAP: begin
                f_wr        = 1'b1;
                f_wr_way    = f_vic;
                f_wr_line   = make_line(d_rd_line.dirty | q_wr, cur_tag);
                f_touch     = 1'b1;
                f_touch_way = f_vic;
                d_wr        = 1'b1;
                d_wr_way    = d_hit_way;
                d_wr_line   = f_rd_line;
                s_touch     = 1'b1;
                s_touch_way = d_hit_way;
            end
            ST_FILL: begin
                d_wr    = 1'b1;
                s_touch = 1'b1;
            end
            default: ;
        endcase
    end

    assign req_ready = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            q_addr    <= '0;
            q_wr      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_tier  <= TIER_NONE;
            rsp_lat   <= '0;
            wb_valid  <= 1'b0;
            wb_addr   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            wb_valid  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_addr <= req_addr;
                        q_wr   <= req_write;
                        st     <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (f_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_tier  <= TIER_FAST;
                        rsp_lat   <= LAT_W'(FAST_LAT);
                        st        <= ST_IDLE;
                    end else if (d_hit) begin
                        st <= ST_SWAP;
                    end else begin
                        st <= ST_FILL;
                    end
                end
                ST_SWAP: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_tier  <= TIER_SLOW;
                    rsp_lat   <= LAT_W'(SLOW_LAT);
                    st        <= ST_IDLE;
                end
                ST_FILL: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_tier  <= TIER_NONE;
                    rsp_lat   <= LAT_W'(MISS_LAT);
                    wb_valid  <= d_rd_line.valid & d_rd_line.dirty;
                    wb_addr   <= {d_rd_line.tag, cur_set};
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tpc_ctrl_chk.sv
module tpc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic [1:0] rsp_tier,
    input logic       wb_valid,
    input logic       f_hit,
    input logic       d_hit
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    rsp_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!req_ready));

    // R10
    rsp_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    // R9
    wb_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (rsp_valid && !rsp_hit && rsp_tier == 2'd0));

    // R7
    single_tier_chk: assert property (@(posedge clk) disable iff (rst)
        !(f_hit && d_hit));

    // R3
    hit_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_tier != 2'd0)));
endmodule

bind tpc_ctrl tpc_ctrl_chk u_tpc_ctrl_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tier(rsp_tier),
    .wb_valid(wb_valid), .f_hit(f_hit), .d_hit(d_hit)
);

// File: tb/test_tpc_ctrl.sv
`timescale 1ns/1ps
module test_tpc_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [11:0] req_addr;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_tier;
    logic [9:0]  rsp_lat;
    logic        wb_valid;
    logic [11:0] wb_addr;

    always #10 clk = ~clk;

    tpc_ctrl i_tpc_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_tier(rsp_tier), .rsp_lat(rsp_lat),
        .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural model: tier 0 fast, tier 1 slow; ord[..][0] is most recent.
    int mtag [2][4][8];
    bit mval [2][4][8];
    bit mdty [2][4][8];
    int ord  [2][4][8];

    task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 8; w++) begin
                    mval[t][s][w] = 1'b0;
                    mdty[t][s][w] = 1'b0;
                    mtag[t][s][w] = 0;
                    ord[t][s][w]  = w;
                end
    endfunction

    function automatic void touch(input int t, input int s, input int w);
        int p = 0;
        for (int i = 0; i < 8; i++) if (ord[t][s][i] == w) p = i;
        for (int i = p; i > 0; i--) ord[t][s][i] = ord[t][s][i-1];
        ord[t][s][0] = w;
    endfunction

    task automatic do_req(input int tag, input int s, input bit wr, input string lbl);
        int fw = -1, sw = -1, n, etier, elat, v, f;
        bit ewb = 1'b0;
        int ewba = 0;
        string r;
        for (int w = 0; w < 8; w++) begin
            if (mval[0][s][w] && mtag[0][s][w] == tag) fw = w;
            if (mval[1][s][w] && mtag[1][s][w] == tag) sw = w;
        end
        if (fw >= 0) begin
            n = 1; etier = 1; elat = 4; r = "R3";
        end else if (sw >= 0) begin
            n = 2; etier = 2; elat = 6; r = "R5";
        end else begin
            n = 2; etier = 0; elat = 256; r = "R4";
            v = ord[1][s][7];
            if (mval[1][s][v] && mdty[1][s][v]) begin
                ewb = 1'b1;
                ewba = (mtag[1][s][v] << 2) | s;
            end
        end
        if (lbl != "") r = lbl;

        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = 12'((tag << 2) | s);
        req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
            chk(rsp_valid == 1'b0, "R10", "early response", int'(rsp_valid), 0);
            @(negedge clk);
        end
        chk(rsp_valid == 1'b1, r, "rsp_valid", int'(rsp_valid), 1);
        chk(int'(rsp_tier) == etier, r, "rsp_tier", int'(rsp_tier), etier);
        chk(rsp_hit == (etier != 0), r, "rsp_hit", int'(rsp_hit), int'(etier != 0));
        chk(int'(rsp_lat) == elat, r, "rsp_lat", int'(rsp_lat), elat);
        chk(wb_valid == ewb, (lbl != "") ? lbl : "R9", "wb_valid", int'(wb_valid), int'(ewb));
        if (ewb)
            chk(int'(wb_addr) == ewba, (lbl != "") ? lbl : "R9", "wb_addr", int'(wb_addr), ewba);

        if (fw >= 0) begin
            mdty[0][s][fw] = mdty[0][s][fw] | wr;
            touch(0, s, fw);
        end else if (sw >= 0) begin
            bit od;
            int ot;
            bit ov;
            f  = ord[0][s][7];
            ov = mval[0][s][f]; od = mdty[0][s][f]; ot = mtag[0][s][f];
            mval[0][s][f] = 1'b1; mtag[0][s][f] = tag; mdty[0][s][f] = mdty[1][s][sw] | wr;
            mval[1][s][sw] = ov; mtag[1][s][sw] = ot; mdty[1][s][sw] = od;
            touch(0, s, f);
            touch(1, s, sw);
        end else begin
            mval[1][s][v] = 1'b1; mtag[1][s][v] = tag; mdty[1][s][v] = wr;
            touch(1, s, v);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
        do_req(33, 1, 0, "R1");

        do_req(5, 0, 0, "R4");
        do_req(5, 0, 0, "R5");
        do_req(5, 0, 0, "R7");
        do_req(5, 0, 1, "R3");

        for (int k = 100; k < 109; k++) do_req(k, 3, 0, "");
        do_req(100, 3, 0, "R8");

        for (int k = 200; k < 207; k++) do_req(k, 1, 1, "");
        do_req(208, 1, 0, "R9");
        do_req(209, 1, 0, "R9");

        for (int k = 300; k < 309; k++) begin
            do_req(k, 2, 0, "");
            do_req(k, 2, 0, "R5");
        end
        do_req(300, 2, 0, "R6");

        do_req(400, 0, 1, "R11");
        do_req(400, 0, 0, "R11");
        for (int k = 410; k < 418; k++) begin
            do_req(k, 0, 0, "");
            do_req(k, 0, 0, "");
        end
        for (int k = 420; k < 429; k++) do_req(k, 0, 0, "R11");

        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_req(int'(lf[4:1]) + 500, int'(lf[6:5]), lf[9], "");
            if (lf[12]) @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule